// File: doc/BRIEF.md
# Integer Multiply-Divide Execution Unit

This unit carries out the eight multiply and divide operations of a 32-bit RISC integer core on two register operands and returns one result word for the destination register. The issue stage raises `start` for one cycle with a 3-bit operation code and both operands. The unit then holds `busy` high and later raises `done` for one cycle, with the answer on `result`. A separate register-file write port is not needed because the answer stays on `result` until the next operation finishes.

Products come from a single-cycle combinational multiplier. It sign-extends or zero-extends each operand on its own, so the signed, unsigned and mixed upper-half forms all share one array. Quotients and remainders come from an iterative restoring divider. It works on operand magnitudes, produces one quotient bit per cycle and fixes the signs in a final step. A zero divisor and the signed overflow case (most negative value divided by minus one) never reach the divider. They are caught when the operation is accepted and return their fixed architectural results, with no trap. The word width is the parameter `W` (default 32).

Top module: `md_unit`

## Requirements
- R1: Operation code 0 (low product) returns bits W-1:0 of the product of the two operands.
- R2: Operation code 1 (high signed×signed) treats both operands as two's complement and returns bits 2W-1:W of the 2W-bit product.
- R3: Operation code 2 (high signed×unsigned) treats the first operand as signed and the second as unsigned and returns bits 2W-1:W of the product.
- R4: Operation code 3 (high unsigned×unsigned) treats both operands as unsigned and returns bits 2W-1:W of the product.
- R5: Operation codes 4 (signed quotient) and 5 (unsigned quotient) return the quotient of the first operand by the second, with signed division truncating toward zero.
- R6: Operation codes 6 (signed remainder) and 7 (unsigned remainder) return the remainder, which in the signed form takes the sign of the dividend.
- R7: With a zero divisor, both quotient codes return all ones and both remainder codes return the dividend unchanged.
- R8: For the signed codes, dividend 1 followed by W-1 zeros divided by all ones gives that same dividend as the quotient and 0 as the remainder.
- R9: If `start` is sampled high in cycle n, `done` is high for exactly one cycle. That cycle is n+2 for multiplies and for the R7/R8 cases, and n+W+2 for every other divide.
- R10: A `start` sampled while `busy` is high is ignored. It changes neither the pending result nor its timing, and it produces no extra `done`.
- R11: `busy` is high from the cycle after an accepted `start` up to, but not including, the `done` cycle. `result` changes only in a `done` cycle and otherwise holds its value.
- R12: After synchronous reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request, sampled on the rising edge |
| op | input | 3 | Operation code (0..7 as listed in R1-R8 order of codes) |
| src_a | input | W | First operand (multiplier or dividend) |
| src_b | input | W | Second operand (multiplicand or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Result word, held between completions |

## Verification
Two situations are hard to reach with ordinary operand sweeps. One is a second request that arrives while a long divide is still running. The other is the signed overflow pair, which occurs only once among all operand combinations. The bench runs with a narrow 8-bit word. Its sweeps cover zero, one, both signed extremes and all ones against one another in every code, plus a strided grid, so the overflow and zero-divisor pairs come up on purpose. A dedicated sequence then pulses `start` in the middle of an unsigned divide. It checks that the first answer arrives on time and is unaltered, and that no second completion ever follows.

// File: rtl/md_pkg.sv
`timescale 1ns/1ps
package md_pkg;

    typedef enum logic [2:0] {
        OP_MUL    = 3'd0,
        OP_MULH   = 3'd1,
        OP_MULHSU = 3'd2,
        OP_MULHU  = 3'd3,
        OP_DIV    = 3'd4,
        OP_DIVU   = 3'd5,
        OP_REM    = 3'd6,
        OP_REMU   = 3'd7
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_QUICK = 2'd1,
        ST_DIV   = 2'd2
    } md_state_e;

    typedef struct packed {
        logic a_sgn;
        logic b_sgn;
        logic is_div;
        logic want_rem;
        logic want_high;
    } md_ctl_t;

    function automatic md_ctl_t md_decode(input md_op_e code);
        md_ctl_t c;
        c.a_sgn     = (code == OP_MULH) || (code == OP_MULHSU) ||
                      (code == OP_DIV)  || (code == OP_REM);
        c.b_sgn     = (code == OP_MULH) || (code == OP_DIV) || (code == OP_REM);
        c.is_div    = code[2];
        c.want_rem  = code[2] & code[1];
        c.want_high = ~code[2] & (code[1] | code[0]);
        return c;
    endfunction

endpackage

// File: rtl/md_mult.sv
`timescale 1ns/1ps
module md_mult #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  md_pkg::md_ctl_t ctl,
    output logic [W-1:0]   prod_sel
);
    localparam int PW = 2 * W;

    logic [PW-1:0] ax, bx, prod;

    // Each operand extended on its own, so one array serves all four forms.
    assign ax   = {{W{ctl.a_sgn & a[W-1]}}, a};
    assign bx   = {{W{ctl.b_sgn & b[W-1]}}, b};
    assign prod = ax * bx;

    assign prod_sel = ctl.want_high ? prod[PW-1:W] : prod[W-1:0];

endmodule

// File: rtl/md_div.sv
`timescale 1ns/1ps
module md_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] dvd_mag,
    input  logic [W-1:0] dvs_mag,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         fin
);
    localparam int CW = $clog2(W) + 1;

    logic [W-1:0]  quo_r, rem_r, dvs_r;
    logic [CW-1:0] cnt;
    logic          active;

    logic [W:0]    shifted;
    logic          take;
    logic [W-1:0]  sub_lo;

    // One restoring step: shift in next dividend bit, try a subtract.
    assign shifted = {rem_r, quo_r[W-1]};
    assign take    = shifted >= {1'b0, dvs_r};
    assign sub_lo  = shifted[W-1:0] - dvs_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_r  <= '0;
            rem_r  <= '0;
            dvs_r  <= '0;
            cnt    <= '0;
            active <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                quo_r  <= dvd_mag;
                rem_r  <= '0;
                dvs_r  <= dvs_mag;
                cnt    <= '0;
                active <= 1'b1;
            end else if (active) begin
                rem_r <= take ? sub_lo : shifted[W-1:0];
                quo_r <= {quo_r[W-2:0], take};
                cnt   <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end
            end
        end
    end

    assign quo = quo_r;
    assign rem = rem_r;

    p_load_starts_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> active);
    p_fin_stops_r9: assert property (@(posedge clk) disable iff (rst)
        fin |-> !active);
    p_fin_single_r9: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin);

endmodule

// File: rtl/md_unit.sv
`timescale 1ns/1ps
module md_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    import md_pkg::*;

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONES = '1;

    md_state_e    st;
    md_ctl_t      ctl_in, ctl_q;
    logic [W-1:0] a_q, b_q;
    logic         neg_quo_q, neg_rem_q;
    logic [W-1:0] result_q;
    logic         done_q;

    logic         accept, a_neg, b_neg, zero_dvs, ovf, slow_div;
    logic [W-1:0] a_mag, b_mag;
    logic [W-1:0] mul_out, quick_res, div_quo, div_rem, slow_res;
    logic         div_fin;

    function automatic logic [W-1:0] negate(input logic [W-1:0] x);
        return (~x) + 1'b1;
    endfunction

    assign ctl_in   = md_decode(md_op_e'(op));
    assign accept   = start && (st == ST_IDLE);
    assign a_neg    = ctl_in.a_sgn & src_a[W-1];
    assign b_neg    = ctl_in.b_sgn & src_b[W-1];
    assign a_mag    = a_neg ? negate(src_a) : src_a;
    assign b_mag    = b_neg ? negate(src_b) : src_b;
    assign zero_dvs = (src_b == '0);
    assign ovf      = ctl_in.a_sgn && (src_a == MOST_NEG) && (src_b == ALL_ONES);
    assign slow_div = ctl_in.is_div && !zero_dvs && !ovf;

    md_mult #(.W(W)) i_mult (
        .a        (a_q),
        .b        (b_q),
        .ctl      (ctl_q),
        .prod_sel (mul_out)
    );

    md_div #(.W(W)) i_div (
        .clk     (clk),
        .rst     (rst),
        .load    (accept && slow_div),
        .dvd_mag (a_mag),
        .dvs_mag (b_mag),
        .quo     (div_quo),
        .rem     (div_rem),
        .fin     (div_fin)
    );

    // Single-step answers: products and the two fixed divide cases.
    always_comb begin
        if (!ctl_q.is_div)
            quick_res = mul_out;
        else if (b_q == '0)
            quick_res = ctl_q.want_rem ? a_q : ALL_ONES;
        else
            quick_res = ctl_q.want_rem ? '0 : a_q;
    end

    always_comb begin
        if (ctl_q.want_rem)
            slow_res = neg_rem_q ? negate(div_rem) : div_rem;
        else
            slow_res = neg_quo_q ? negate(div_quo) : div_quo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ctl_q     <= '0;
            a_q       <= '0;
            b_q       <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            result_q  <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        ctl_q     <= ctl_in;
                        a_q       <= src_a;
                        b_q       <= src_b;
                        neg_quo_q <= a_neg ^ b_neg;
                        neg_rem_q <= a_neg;
                        st        <= slow_div ? ST_DIV : ST_QUICK;
                    end
                end
                ST_QUICK: begin
                    result_q <= quick_res;
                    done_q   <= 1'b1;
                    st       <= ST_IDLE;
                end
                ST_DIV: begin
                    if (div_fin) begin
                        result_q <= slow_res;
                        done_q   <= 1'b1;
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (st != ST_IDLE);
    assign done   = done_q;
    assign result = result_q;

    p_quick_finish_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_QUICK) |=> done);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    p_hold_result_r11: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));
    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(a_q) && $stable(b_q) && $stable(ctl_q)));
    p_zero_quo_r7: assert property (@(posedge clk) disable iff (rst)
        (done && ctl_q.is_div && !ctl_q.want_rem && b_q == '0) |-> (result == ALL_ONES));
    p_ovf_rem_r8: assert property (@(posedge clk) disable iff (rst)
        (done && ctl_q.want_rem && ctl_q.a_sgn && a_q == MOST_NEG && b_q == ALL_ONES)
        |-> (result == '0));

endmodule

// File: tb/test_md_unit.sv
`timescale 1ns/1ps
module test_md_unit;

    localparam int W = 8;
    localparam longint MASK = (longint'(1) << W) - 1;
    localparam longint MINV = longint'(1) << (W - 1);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [2:0]   op = '0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic         busy, done;
    logic [W-1:0] result;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    md_unit #(.W(W)) i_md_unit (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op     (op),
        .src_a  (src_a),
        .src_b  (src_b),
        .busy   (busy),
        .done   (done),
        .result (result)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint sx(input longint v);
        return v[W-1] ? v - (longint'(1) << W) : v;
    endfunction

    function automatic longint model(input int code, input longint a, input longint b);
        longint sa = sx(a);
        longint sb = sx(b);
        case (code)
            0: return (sa * sb) & MASK;
            1: return ((sa * sb) >>> W) & MASK;
            2: return ((sa * b) >>> W) & MASK;
            3: return ((a * b) >> W) & MASK;
            4: if (b == 0) return MASK;
               else if (a == MINV && b == MASK) return a;
               else return (sa / sb) & MASK;
            5: return (b == 0) ? MASK : (a / b);
            6: if (b == 0) return a;
               else if (a == MINV && b == MASK) return 0;
               else return (sa % sb) & MASK;
            default: return (b == 0) ? a : (a % b);
        endcase
    endfunction

    function automatic bit is_quick(input int code, input longint a, input longint b);
        if (code < 4) return 1'b1;
        if (b == 0) return 1'b1;
        if ((code == 4 || code == 6) && a == MINV && b == MASK) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string tag_of(input int code, input longint a, input longint b);
        if (code >= 4 && b == 0) return "R7";
        if ((code == 4 || code == 6) && a == MINV && b == MASK) return "R8";
        case (code)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4, 5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic run_op(input int code, input longint a, input longint b);
        int     lat;
        int     want;
        longint exp;
        @(negedge clk);
        start = 1'b1;
        op    = 3'(code);
        src_a = W'(a);
        src_b = W'(b);
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        check(busy === 1'b1 && done === 1'b0, "R11 busy after accept", {62'd0, busy, done}, 64'h2);
        while (done !== 1'b1 && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        exp  = model(code, a, b);
        want = is_quick(code, a, b) ? 2 : W + 2;
        check(longint'(result) == exp, tag_of(code, a, b), longint'(result), exp);
        check(lat == want, "R9 latency", lat, want);
        check(busy === 1'b0, "R11 busy low at done", longint'(busy), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        longint corners [6] = '{0, 1, 2, MINV - 1, MINV, MASK};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check(busy === 1'b0 && done === 1'b0, "R12 control", {62'd0, busy, done}, 0);
        check(result === '0, "R12 result", longint'(result), 0);

        // Corner operand pairs in every code (reaches R7 and R8 cases)
        for (int c = 0; c < 8; c++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    run_op(c, corners[i], corners[j]);

        // Strided grid across the operand space
        for (int c = 0; c < 8; c++)
            for (int a = 0; a < 256; a += 13)
                for (int b = 0; b < 256; b += 17)
                    run_op(c, longint'(a), longint'(b));

        // R10: start pulse in the middle of an unsigned divide
        begin
            int lat;
            int extra;
            @(negedge clk);
            start = 1'b1; op = 3'd5; src_a = W'(200); src_b = W'(7);
            @(negedge clk);
            start = 1'b0;
            lat = 1;
            repeat (3) begin @(negedge clk); lat++; end
            start = 1'b1; op = 3'd0; src_a = W'(3); src_b = W'(3);
            @(negedge clk);
            start = 1'b0;
            lat++;
            while (done !== 1'b1 && lat < 100) begin @(negedge clk); lat++; end
            check(longint'(result) == 28, "R10 result kept", longint'(result), 28);
            check(lat == W + 2, "R10 timing kept", lat, W + 2);
            extra = 0;
            repeat (W + 6) begin
                @(negedge clk);
                if (done === 1'b1) extra++;
                // R11: result held while idle
                check(longint'(result) == 28 && busy === 1'b0, "R11 hold", longint'(result), 28);
            end
            check(extra == 0, "R10 no extra done", extra, 0);
        end

        // R11: back-to-back operations, result changes only at completion
        run_op(6, MINV + 3, 5);
        run_op(0, 15, 17);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule